// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Shared Dividers

This block drives four pulse-width modulated outputs from a small register bank written over a plain single-cycle bus. Four 16-bit divider generators each produce a one-clock tick every N input clocks. Each channel chooses one of those dividers and runs an 8-bit phase counter that steps once per tick, so a full output period is 256 ticks long. The output is high while the phase is below the channel's duty count, so each period starts high and ends low.

Software sets a divide value and a duty count, turns on the channel's phase counter and then enables its output. Any write to a duty register, or to the divider that a channel uses, starts that channel's period over at phase zero at once, abandoning the period that was running. A bypass bit forces an enabled output fully on, and a channel whose output enable is clear drives low. The bus has no flow control: a write lands on the clock edge where `bus_wr` is high, and `bus_rdata` shows the word addressed by `bus_addr` in the same cycle.

Top module: `pwm_bank_top`

## Requirements
- R1: After reset every register reads zero and all four outputs are low.
- R2: Register words sit at byte addresses 0x00 (output enable for channel c at bit c, bypass for channel c at bit 8+c), 0x04 (phase counter run for channel c at bit c), 0x08+4k (divider k value in bits 15:0) and 0x18+4c (channel c duty count in bits 7:0, divider select in bits 9:8). Each reads back what was written, bits outside these fields read zero, and any other address reads zero and ignores writes.
- R3: With divide value N≥1 and the run bit set, an enabled, non-bypassed channel's output repeats every 256·N clocks.
- R4: Within each period the output is high first, for duty·N clocks, then low.
- R5: A duty count of zero keeps an enabled, non-bypassed output low.
- R6: A channel whose output enable bit is clear drives low, whatever its other settings.
- R7: An enabled channel with its bypass bit set drives high, even with duty zero.
- R8: When the selected divider's value is zero the phase counter stays at zero, so the output stays constant (high when duty is non-zero).
- R9: A write to a channel's duty register restarts its period at once: with a non-zero duty the output is high in the second clock after the write edge, even if the old period was in its low part.
- R10: A write to a divider register restarts every channel that selects that divider, so channels sharing a divider with equal duty produce identical waveforms.
- R11: When a channel's run bit is clear its phase counter is held at zero, so an enabled output with non-zero duty stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register word (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_addr`, combinational |
| pwm_out | output | 4 | Modulated outputs, one bit per channel |

## Verification
The assertions take for granted that writes arrive as single-cycle strobes to word-aligned addresses and that the channel count fits the eight bypass positions of the control word; under those inputs they hold on the phase counters and outputs for any register contents. The stimulus only issues one-cycle writes at the falling edge to the ten defined word addresses plus one unmapped word, and it measures pulse widths only after a full period has passed since the last restart, so a partial first divider step never enters a timing check.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // Word index of the control words; divider and duty words follow.
  localparam int WORD_CTRL = 0;
  localparam int WORD_RUN  = 1;
  localparam int WORD_DIV0 = 2;
  // Bit position where the bypass flags start in the control word.
  localparam int BYP_LSB   = 8;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DIV_W  = 16,
  parameter int PH_W   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NCH-1:0]             en,
  output logic [NCH-1:0]             byp,
  output logic [NCH-1:0]             run,
  output logic [NCH-1:0][DIV_W-1:0]  div_val,
  output logic [NCH-1:0][PH_W-1:0]   duty,
  output logic [NCH-1:0][SEL_W-1:0]  sel,
  output logic [NCH-1:0]             div_wr,
  output logic [NCH-1:0]             duty_wr
);
  localparam int WORD_DUTY0 = WORD_DIV0 + NCH;

  logic [IDX_W-1:0] widx;
  logic             hit_ctrl, hit_run;

  assign widx     = addr[ADDR_W-1:2];
  assign hit_ctrl = (widx == IDX_W'(WORD_CTRL));
  assign hit_run  = (widx == IDX_W'(WORD_RUN));

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      div_wr[c]  = wr && (widx == IDX_W'(WORD_DIV0 + c));
      duty_wr[c] = wr && (widx == IDX_W'(WORD_DUTY0 + c));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= '0;
      byp     <= '0;
      run     <= '0;
      div_val <= '0;
      duty    <= '0;
      sel     <= '0;
    end else begin
      if (wr && hit_ctrl) begin
        en  <= wdata[NCH-1:0];
        byp <= wdata[BYP_LSB +: NCH];
      end
      if (wr && hit_run) begin
        run <= wdata[NCH-1:0];
      end
      for (int c = 0; c < NCH; c++) begin
        if (div_wr[c]) begin
          div_val[c] <= wdata[DIV_W-1:0];
        end
        if (duty_wr[c]) begin
          duty[c] <= wdata[PH_W-1:0];
          sel[c]  <= wdata[PH_W +: SEL_W];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl) begin
      rdata[NCH-1:0]         = en;
      rdata[BYP_LSB +: NCH]  = byp;
    end
    if (hit_run) begin
      rdata[NCH-1:0] = run;
    end
    for (int c = 0; c < NCH; c++) begin
      if (widx == IDX_W'(WORD_DIV0 + c)) begin
        rdata[DIV_W-1:0] = div_val[c];
      end
      if (widx == IDX_W'(WORD_DUTY0 + c)) begin
        rdata[PH_W-1:0]     = duty[c];
        rdata[PH_W +: SEL_W] = sel[c];
      end
    end
  end
endmodule

// File: rtl/pwm_divider.sv
module pwm_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] limit,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == limit - DIV_W'(1));
  assign tick   = (limit != '0) && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || limit == '0 || at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int NCH  = 4,
  parameter int PH_W = 8,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             byp,
  input  logic             run,
  input  logic [PH_W-1:0]  duty,
  input  logic [SEL_W-1:0] sel,
  input  logic [NCH-1:0]   ticks,
  input  logic [NCH-1:0]   div_wr,
  input  logic             duty_wr,
  output logic [PH_W-1:0]  ph,
  output logic             out
);
  logic restart;

  assign restart = duty_wr || div_wr[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (restart || !run) begin
      ph <= '0;
    end else if (ticks[sel]) begin
      ph <= ph + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out <= 1'b0;
    end else begin
      out <= en && (byp || (ph < duty));
    end
  end
endmodule

// File: rtl/pwm_bank_top.sv
module pwm_bank_top #(
  parameter int NCH    = 4,
  parameter int DIV_W  = 16,
  parameter int PH_W   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0]            en, byp, run, div_wr, duty_wr, ticks;
  logic [NCH-1:0][DIV_W-1:0] div_val;
  logic [NCH-1:0][PH_W-1:0]  duty, ph_all;
  logic [NCH-1:0][SEL_W-1:0] sel;

  pwm_regs #(
    .NCH(NCH), .DIV_W(DIV_W), .PH_W(PH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata),
    .en(en), .byp(byp), .run(run), .div_val(div_val),
    .duty(duty), .sel(sel), .div_wr(div_wr), .duty_wr(duty_wr)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_div
    pwm_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .limit(div_val[k]),
      .restart(div_wr[k]), .tick(ticks[k])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_channel #(.NCH(NCH), .PH_W(PH_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(en[c]), .byp(byp[c]), .run(run[c]),
      .duty(duty[c]), .sel(sel[c]), .ticks(ticks), .div_wr(div_wr),
      .duty_wr(duty_wr[c]), .ph(ph_all[c]), .out(pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH   = 4,
  parameter int DIV_W = 16,
  parameter int PH_W  = 8,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            en,
  input logic [NCH-1:0]            byp,
  input logic [NCH-1:0]            run,
  input logic [NCH-1:0][DIV_W-1:0] div_val,
  input logic [NCH-1:0][PH_W-1:0]  duty,
  input logic [NCH-1:0][SEL_W-1:0] sel,
  input logic [NCH-1:0][PH_W-1:0]  ph_all,
  input logic [NCH-1:0]            pwm_out
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_disabled_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en[c] |=> !pwm_out[c]);

    assert_bypass_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en[c] && byp[c]) |=> pwm_out[c]);

    assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en[c] && !byp[c] && duty[c] == '0) |=> !pwm_out[c]);

    assert_stopped_divider_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (div_val[sel[c]] == '0) |=> (ph_all[c] == '0));

    assert_run_clear_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !run[c] |=> (ph_all[c] == '0));

    assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ph_all[c] == $past(ph_all[c]) ||
                ph_all[c] == $past(ph_all[c]) + PH_W'(1) ||
                ph_all[c] == '0));
  end
endmodule

bind pwm_bank_top pwm_bank_chk #(.NCH(NCH), .DIV_W(DIV_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .byp(byp), .run(run),
  .div_val(div_val), .duty(duty), .sel(sel), .ph_all(ph_all),
  .pwm_out(pwm_out)
);

// File: tb/pwm_bank_top_tb.sv
`timescale 1ns/1ps
module pwm_bank_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] ctrl_s = '0;
  logic [31:0] run_s = '0;

  always #2.5 clk = ~clk;

  pwm_bank_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, int'(bus_rdata), int'(exp));
  endtask

  task automatic set_ctrl(logic [31:0] v); ctrl_s = v; wr(8'h00, v); endtask
  task automatic set_run(logic [31:0] v);  run_s = v;  wr(8'h04, v); endtask

  task automatic wait_rise(int ch);
    logic p;
    p = pwm_out[ch];
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (!p && pwm_out[ch]) return;
      p = pwm_out[ch];
    end
  endtask

  // Skips one full period after the first rise, then measures high time and period.
  task automatic measure(int ch, output int hi, output int per);
    logic p;
    hi = 0; per = 0;
    wait_rise(ch);
    wait_rise(ch);
    p = pwm_out[ch];
    for (int i = 0; i < 6000; i++) begin
      if (pwm_out[ch]) hi++;
      per++;
      @(negedge clk);
      if (!p && pwm_out[ch]) return;
      p = pwm_out[ch];
    end
  endtask

  // Counts samples over n cycles where the channel differs from the level.
  task automatic hold_chk(string req, int ch, logic level, int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch] != level) bad++;
    end
    check(req, bad, 0);
  endtask

  task automatic t_reset();
    for (int w = 0; w < 10; w++) rd_chk("R1 reset readback", 8'(4 * w), 32'h0);
    check("R1 outputs low", int'(pwm_out), 0);
  endtask

  task automatic t_regmap();
    wr(8'h00, 32'hFFFF_FFFF); rd_chk("R2 ctrl fields", 8'h00, 32'h0000_0F0F);
    wr(8'h04, 32'hFFFF_FFFF); rd_chk("R2 run field", 8'h04, 32'h0000_000F);
    wr(8'h0C, 32'hFFFF_1234); rd_chk("R2 divider1 field", 8'h0C, 32'h0000_1234);
    wr(8'h20, 32'hFFFF_FFFF); rd_chk("R2 duty2 fields", 8'h20, 32'h0000_03FF);
    wr(8'h28, 32'hFFFF_FFFF); rd_chk("R2 unmapped word", 8'h28, 32'h0);
    set_ctrl(32'h0); set_run(32'h0);
    wr(8'h0C, 32'h0); wr(8'h20, 32'h0);
    rd_chk("R2 ctrl cleared", 8'h00, 32'h0);
  endtask

  task automatic t_timing();
    int hi, per;
    wr(8'h08, 32'd2);                     // divider 0: N=2
    wr(8'h0C, 32'd3);                     // divider 1: N=3
    wr(8'h18, 32'h0000_0040);             // ch0 duty 64, divider 0
    wr(8'h1C, 32'h0000_01C8);             // ch1 duty 200, divider 1
    wr(8'h20, 32'h0000_00FF);             // ch2 duty 255, divider 0
    set_run(32'h7); set_ctrl(32'h7);
    measure(0, hi, per);
    check("R3 ch0 period", per, 512); check("R4 ch0 high", hi, 128);
    measure(1, hi, per);
    check("R3 ch1 period", per, 768); check("R4 ch1 high", hi, 600);
    measure(2, hi, per);
    check("R3 ch2 period", per, 512); check("R4 ch2 high", hi, 510);
  endtask

  task automatic t_zero_duty();
    wr(8'h24, 32'h0);
    set_run(run_s | 32'h8); set_ctrl(ctrl_s | 32'h8);
    hold_chk("R5 duty zero low", 3, 1'b0, 600);
  endtask

  task automatic t_disable();
    set_ctrl(ctrl_s & ~32'h1);
    @(negedge clk);
    hold_chk("R6 disabled low", 0, 1'b0, 600);
  endtask

  task automatic t_bypass();
    set_ctrl(ctrl_s | 32'h800);
    @(negedge clk);
    hold_chk("R7 bypass high", 3, 1'b1, 600);
  endtask

  task automatic t_div_zero();
    wr(8'h10, 32'h0);                     // divider 2 stopped
    wr(8'h20, 32'h0000_020A);             // ch2 duty 10, divider 2
    @(negedge clk);
    hold_chk("R8 stopped divider constant", 2, 1'b1, 600);
  endtask

  task automatic t_restart();
    int waited = 0;
    while (pwm_out[1] !== 1'b0 && waited < 2000) begin
      @(negedge clk); waited++;
    end
    check("R9 low before rewrite", int'(pwm_out[1]), 0);
    wr(8'h1C, 32'h0000_01C8);
    @(negedge clk);
    check("R9 high after rewrite", int'(pwm_out[1]), 1);
  endtask

  task automatic t_shared();
    int diff = 0, toggles = 0;
    logic p;
    wr(8'h18, 32'h0000_0064);             // ch0 duty 100, divider 0
    wr(8'h1C, 32'h0000_0064);             // ch1 duty 100, divider 0
    set_run(run_s | 32'h3); set_ctrl(ctrl_s | 32'h3);
    wr(8'h08, 32'd2);                     // restart both
    p = pwm_out[0];
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (pwm_out[0] != pwm_out[1]) diff++;
      if (pwm_out[0] != p) toggles++;
      p = pwm_out[0];
    end
    check("R10 shared divider mismatch", diff, 0);
    check("R10 shared divider toggles", int'(toggles > 0), 1);
  endtask

  task automatic t_run_clear();
    set_run(run_s & ~32'h1);
    @(negedge clk);
    hold_chk("R11 run clear holds high", 0, 1'b1, 600);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_regmap();
    t_timing();
    t_zero_duty();
    t_disable();
    t_bypass();
    t_div_zero();
    t_restart();
    t_shared();
    t_run_clear();
    summary();
  end
endmodule